// File: doc/BRIEF.md
# Programmable-Resolution Time Tag Counter

A 16-bit free-running time base that a bus terminal shares across its controller, remote-terminal and monitor roles. In its internal modes a prescaler, running from the system clock, advances the count once per selected interval. The interval runs from 2 to 64 microseconds per LSB in power-of-two steps. The prescaler's divide ratio follows a parameter that gives the system clock frequency in MHz, so a 16 MHz or a 12 MHz clock produces the same time resolution. Two further codes of the resolution selector switch the count to an external tick line. That line is synchronised into the clock domain, and each of its rising edges adds one to the count.

The host loads the count through a write port. The protocol engine raises a one-cycle capture request at the start of a message and gets back the value the count held in that cycle, ready to store as the message's time tag. A one-cycle flag marks each wrap from all ones back to zero.

Top module: `ttag_counter`

## Requirements
- R1: While rst_n is low, count, cap_value, rollover and cap_valid are all zero.
- R2: With res_sel code c in 0..5, where code c means 2^(c+1) microseconds per LSB, count advances by exactly one every CLK_MHZ * 2^(c+1) clock cycles.
- R3: Codes 6 and 7 select the external source. In these codes the prescaler never advances count. In codes 0..5, activity on ext_tick has no effect on count.
- R4: In external mode, a low-to-high change of ext_tick that is sampled at clock edge k increments count by one at edge k+2. Holding ext_tick high does not increment count again.
- R5: When wr_en is high at an edge, count takes wr_data at that edge and the prescaler restarts. The next internal increment therefore comes one full period after the write.
- R6: If a write and an increment fall on the same edge, the written value wins and the increment is lost.
- R7: count wraps from 0xFFFF to 0x0000. rollover is high for exactly the one cycle in which count first shows 0x0000 after the wrap. A host write of zero never raises rollover.
- R8: When cap_req is high at an edge, cap_value takes the count present before that edge, so an increment at the same edge is not included. cap_valid is high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| res_sel | input | 3 | Resolution code: 0..5 select 2..64 us per LSB; 6 and 7 select the external tick |
| ext_tick | input | 1 | Asynchronous external count source |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Value loaded into the count |
| cap_req | input | 1 | Capture request from the protocol engine |
| count | output | 16 | Current time tag value |
| rollover | output | 1 | One-cycle pulse after a wrap to zero |
| cap_value | output | 16 | Captured time tag |
| cap_valid | output | 1 | One-cycle pulse when cap_value is updated |

## Verification
The assertions treat every input as synchronous to clk, apart from ext_tick. ext_tick may change at any time, and no property refers to it directly. The step property assumes that a write is the only way count can move by more than one. The capture and rollover properties assume that the engine raises cap_req as a plain level and gets no back-pressure. The bench changes every input only on the falling clock edge. When it switches res_sel it first writes the count so that the prescaler starts clean. It holds the external tick at each level for at least one full cycle, and it places writes and captures on the exact edges where an increment lands.

// File: rtl/ttag_pkg.sv
package ttag_pkg;

   typedef enum logic [2:0] {
      RES_2US   = 3'd0,
      RES_4US   = 3'd1,
      RES_8US   = 3'd2,
      RES_16US  = 3'd3,
      RES_32US  = 3'd4,
      RES_64US  = 3'd5,
      RES_EXT_A = 3'd6,
      RES_EXT_B = 3'd7
   } res_code_e;

   // Codes above the slowest internal resolution hand the count to the external tick.
   function automatic logic is_ext(input logic [2:0] code);
      return code > RES_64US;
   endfunction

endpackage

// File: rtl/ttag_prescaler.sv
module ttag_prescaler #(
   parameter int CLK_MHZ = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       hold,
   input  logic [2:0] res_sel,
   output logic       tick
);
   // Longest period is CLK_MHZ*64 cycles; one spare bit absorbs the shift.
   localparam int PRE_W = $clog2(CLK_MHZ * 128);
   localparam logic [PRE_W:0] BASE_V = (PRE_W + 1)'(CLK_MHZ * 2);
   localparam logic [PRE_W:0] ONE_V  = (PRE_W + 1)'(1);

   logic [PRE_W:0] pre_q;
   logic [PRE_W:0] limit;

   always_comb begin
      limit = (BASE_V << res_sel) - ONE_V;
      // ">=" lets a switch to a shorter interval take effect at once.
      tick  = !hold && (pre_q >= limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 pre_q <= '0;
      else if (clr || hold || tick) pre_q <= '0;
      else                        pre_q <= pre_q + ONE_V;
   end

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("ttag_prescaler: CLK_MHZ must be at least 1");
      end
   endgenerate
endmodule

// File: rtl/ttag_edge_sync.sv
module ttag_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-1:0], din};
   end

   assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ttag_edge_sync: at least two synchroniser stages required");
      end
   endgenerate
endmodule

// File: rtl/ttag_count_core.sv
module ttag_count_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         inc,
   input  logic         cap_req,
   output logic [W-1:0] count,
   output logic         rollover,
   output logic [W-1:0] cap_value,
   output logic         cap_valid
);
   localparam logic [W-1:0] ALL_ONES = '1;
   localparam logic [W-1:0] ONE_V    = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count    <= '0;
         rollover <= 1'b0;
      end else if (wr_en) begin
         count    <= wr_data;
         rollover <= 1'b0;
      end else if (inc) begin
         count    <= count + ONE_V;
         rollover <= (count == ALL_ONES);
      end else begin
         rollover <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_value <= '0;
         cap_valid <= 1'b0;
      end else begin
         cap_valid <= cap_req;
         if (cap_req) cap_value <= count;
      end
   end
endmodule

// File: rtl/ttag_counter.sv
module ttag_counter #(
   parameter int CLK_MHZ     = 16,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       res_sel,
   input  logic             ext_tick,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cap_req,
   output logic [CNT_W-1:0] count,
   output logic             rollover,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_valid
);
   import ttag_pkg::*;

   logic ext_mode;
   logic pre_tick;
   logic ext_rise;
   logic inc;

   assign ext_mode = is_ext(res_sel);

   ttag_prescaler #(.CLK_MHZ(CLK_MHZ)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .hold(ext_mode),
      .res_sel(res_sel), .tick(pre_tick)
   );

   ttag_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_tick), .rise(ext_rise)
   );

   assign inc = ext_mode ? ext_rise : pre_tick;

   ttag_count_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .inc(inc), .cap_req(cap_req), .count(count), .rollover(rollover),
      .cap_value(cap_value), .cap_valid(cap_valid)
   );

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ttag_counter: CNT_W must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/ttag_counter_chk.sv
module ttag_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic             cap_req,
   input logic [CNT_W-1:0] count,
   input logic             rollover,
   input logic [CNT_W-1:0] cap_value,
   input logic             cap_valid
);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && !rollover && !cap_valid));

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (count == $past(count) || count == $past(count) + ONE_V));

   a_r5_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (count == $past(wr_data)));

   a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |-> (count == '0 && $past(count) == '1 && !$past(wr_en)));

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req |=> (cap_valid && cap_value == $past(count)));

   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_req |=> !cap_valid);
endmodule

bind ttag_counter ttag_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .cap_req(cap_req), .count(count), .rollover(rollover),
   .cap_value(cap_value), .cap_valid(cap_valid)
);

// File: tb/ttag_counter_bench.sv
`timescale 1ns/1ps
module ttag_counter_bench;
   localparam int CLK_MHZ = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  res_sel = 3'd0;
   logic        ext_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = 16'd0;
   logic        cap_req = 1'b0;
   logic [15:0] count;
   logic        rollover;
   logic [15:0] cap_value;
   logic        cap_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ttag_counter #(.CLK_MHZ(CLK_MHZ)) u_ttag_counter (
      .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .ext_tick(ext_tick),
      .wr_en(wr_en), .wr_data(wr_data), .cap_req(cap_req), .count(count),
      .rollover(rollover), .cap_value(cap_value), .cap_valid(cap_valid)
   );

   // Behavioural reference
   int m_pre, m_cnt, m_capv;
   bit m_roll, m_capok, m_s1, m_s2, m_s3;

   always @(posedge clk) begin
      int period;
      bit ext, inc, edge_seen;
      int old;
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_capv = 0; m_roll = 0; m_capok = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         old = m_cnt;
         ext = (res_sel >= 3'd6);
         edge_seen = m_s2 && !m_s3;
         inc = 0;
         period = CLK_MHZ * (2 << res_sel);
         if (ext) begin m_pre = 0; inc = edge_seen; end
         else if (m_pre >= period - 1) begin m_pre = 0; inc = 1; end
         else m_pre = m_pre + 1;
         if (wr_en) begin m_cnt = wr_data; m_pre = 0; m_roll = 0; end
         else if (inc) begin m_roll = (m_cnt == 65535); m_cnt = (m_cnt + 1) & 16'hFFFF; end
         else m_roll = 0;
         m_capok = cap_req;
         if (cap_req) m_capv = old;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_tick;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      check(count == m_cnt[15:0], "R2 count vs model", count, m_cnt);
      check(rollover == m_roll, "R7 rollover vs model", rollover, m_roll);
      check(cap_valid == m_capok, "R8 cap_valid vs model", cap_valid, m_capok);
      check(cap_value == m_capv[15:0], "R8 cap_value vs model", cap_value, m_capv);
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic host_write(input logic [2:0] sel, input logic [15:0] v);
      res_sel = sel; wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      int n;
      cyc(3);
      check(count == 0 && rollover == 0 && cap_valid == 0 && cap_value == 0,
            "R1 reset state", count, 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 / R5: interval per code measured from a write
      for (int c = 0; c < 6; c++) begin
         host_write(c[2:0], 16'd0);
         n = 0;
         while (count == 16'd0 && n < 1000) begin @(negedge clk); n++; end
         check(n == CLK_MHZ * (2 << c), "R2 R5 period after write", n, CLK_MHZ * (2 << c));
      end

      // R3: internal mode ignores ext_tick pulses (count follows only the prescaler)
      host_write(3'd5, 16'd50);
      for (int k = 0; k < 5; k++) begin ext_tick = 1; cyc(3); ext_tick = 0; cyc(3); end
      check(count == 16'd50, "R3 ext_tick ignored in internal mode", count, 50);

      // R3: external codes never advance from the prescaler
      host_write(3'd6, 16'd7);
      cyc(300);
      check(count == 16'd7, "R3 prescaler idle in external mode", count, 7);

      // R4: one increment per rising edge, latency two edges, level held
      for (int s = 6; s < 8; s++) begin
         host_write(s[2:0], 16'd100);
         ext_tick = 1'b1;   // sampled at edge k
         cyc(2);            // edges k, k+1
         check(count == 16'd100, "R4 no increment before edge k+2", count, 100);
         cyc(1);
         check(count == 16'd101, "R4 increment at edge k+2", count, 101);
         cyc(20);
         check(count == 16'd101, "R4 held level counts once", count, 101);
         ext_tick = 1'b0; cyc(3);
      end

      // R6: write on the increment edge wins
      host_write(3'd6, 16'd200);
      ext_tick = 1'b1;
      cyc(2);
      wr_en = 1'b1; wr_data = 16'h1234;
      cyc(1);
      wr_en = 1'b0;
      cyc(5);
      check(count == 16'h1234, "R6 write beats increment", count, 16'h1234);
      ext_tick = 1'b0; cyc(3);

      // R8: capture on the increment edge takes the old value
      host_write(3'd6, 16'd300);
      ext_tick = 1'b1;
      cyc(2);
      cap_req = 1'b1;
      cyc(1);
      cap_req = 1'b0;
      check(cap_valid == 1'b1 && cap_value == 16'd300, "R8 capture pre-increment", cap_value, 300);
      check(count == 16'd301, "R8 increment still taken", count, 301);
      cyc(1);
      check(cap_valid == 1'b0, "R8 cap_valid single cycle", cap_valid, 0);
      ext_tick = 1'b0; cyc(3);

      // R7: wrap and rollover pulse
      host_write(3'd0, 16'hFFFE);
      n = 0;
      while (count != 16'd0 && n < 100) begin @(negedge clk); n++; end
      check(rollover == 1'b1, "R7 rollover with zero", rollover, 1);
      cyc(1);
      check(rollover == 1'b0, "R7 rollover one cycle", rollover, 0);
      host_write(3'd6, 16'd0);
      check(rollover == 1'b0, "R7 no rollover on write of zero", rollover, 0);

      // Mixed random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         res_sel  = ($urandom_range(0, 99) < 2) ? 3'($urandom_range(0, 7)) : res_sel;
         wr_en    = ($urandom_range(0, 99) < 3);
         wr_data  = ($urandom_range(0, 3) == 0) ? 16'hFFFF - 16'($urandom_range(0, 3))
                                                : 16'($urandom);
         cap_req  = ($urandom_range(0, 9) == 0);
         ext_tick = ($urandom_range(0, 3) == 0) ? ~ext_tick : ext_tick;
         @(negedge clk);
      end
      wr_en = 0; cap_req = 0;
      cyc(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule